// File: doc/BRIEF.md
# Rotating Four-Region Trace Memory Writer

This block takes a stream of 32-bit trace words and stores them into four memory regions of equal size, one region after another. Software programs one base address per region and a single region size in bytes. Each accepted word leaves the block as a write request that carries its own address and data over a valid/ready pair. The byte offset inside the active region advances by four for every word written.

When the last word of a region is accepted, the block flags that region as complete for one cycle and moves to the start of the next region. After region 3 it returns to region 0 for as long as tracing stays enabled. A completed region stays held until the host pulses its release bit. A record whose first word would land in a held region is consumed and thrown away, and a sticky overflow flag is raised. Nothing is overwritten.

Words are grouped into records of `RecWords` words. The region size must be a whole number of records. When tracing is switched off, the block finishes the record in progress and then stops taking words. While stopped, it shows the region index and byte offset it reached. Enabling it again starts over at region 0, offset 0.

Top module: `rdw_ring_writer`

## Requirements
- R1: While writing, `wrAddr` equals `baseAddr[fillIdx] + fillOffset`, `wrData` equals `inData`, and each accepted word raises `fillOffset` by 4. While `wrReady` is low, `inReady` is low and the position holds.
- R2: Regions fill in the order 0, 1, 2, 3. After a region completes, writing continues at offset 0 of the next region.
- R3: After region 3 completes, writing continues at region 0 offset 0 while `traceEn` stays high.
- R4: `doneValid` is high with `doneIdx` equal to the region index in exactly the cycle the last word of that region (offset `bufSize-4`) is accepted.
- R5: `bufSize` is 24 bits wide and accepts 4 MiB (0x400000). With that size, words are written at ascending addresses and no completion is flagged before the region is full.
- R6: After `traceEn` falls in the middle of a record, the rest of that record is still accepted. After that, `inReady` and `wrValid` stay low, and `stopped` is high one cycle after the last accepted word.
- R7: While `stopped` is high, `fillIdx` and `fillOffset` give the region and the byte offset reached, with `fillOffset` counted from the region's base.
- R8: A completed region is held until its `bufRelease` bit is pulsed. A record that starts in a held region is accepted with `inReady` high and `wrValid` low. The position does not move, and `overflow` is set and stays set while running.
- R9: After the held region is released, the next record is written from offset 0 of that region.
- R10: If `traceEn` is high while stopped, the next cycle shows `stopped` low, `fillIdx` 0, `fillOffset` 0 and `overflow` 0.
- R11: After reset, `stopped` is 1, and `inReady`, `wrValid`, `doneValid`, `overflow`, `fillIdx` and `fillOffset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Tracing enable; a fall stops the block at the next record boundary |
| inData | input | 32 | Trace word |
| inValid | input | 1 | Trace word present |
| inReady | output | 1 | Trace word accepted this cycle when `inValid` is also high |
| baseAddr | input | 4 x AddrW | Byte base address of each region, index 0..3 |
| bufSize | input | SizeW (24) | Region size in bytes, a multiple of 4*RecWords |
| bufRelease | input | 4 | One-cycle pulse per region: the host has drained it |
| wrAddr | output | AddrW (32) | Byte address of the write request |
| wrData | output | 32 | Data of the write request |
| wrValid | output | 1 | Write request present |
| wrReady | input | 1 | Memory side takes the write request |
| doneValid | output | 1 | A region completed this cycle |
| doneIdx | output | 2 | Index of the completed region |
| overflow | output | 1 | Sticky: a record was dropped because its region was held |
| stopped | output | 1 | Block is idle and accepts no words |
| fillIdx | output | 2 | Active region index |
| fillOffset | output | SizeW (24) | Byte offset reached in the active region |

## Verification
The write request, `inReady`, `doneValid` and `doneIdx` are combinational from the current word and state. They are due in the same cycle the word is presented, so the bench drives each word on a falling edge and samples these outputs 1 ns later, before the next rising edge. `fillIdx`, `fillOffset`, `overflow` and `stopped` are registers and change one rising edge after the event that moves them. The bench reads them at the falling edge after that edge; for a stop, that is the edge after the last word of the record.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  localparam int NumBuf = 4;
  localparam int IdxW   = $clog2(NumBuf);

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // return to region 0, offset 0
    logic advance;   // one word written this cycle
  } dpCmd_t;
endpackage

// File: rtl/rdw_datapath.sv
module rdw_datapath
  import rdw_pkg::*;
#(
  parameter int AddrW = 32,
  parameter int SizeW = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCmd_t                        cmd,
  input  logic [NumBuf-1:0][AddrW-1:0]  baseAddr,
  input  logic [SizeW-1:0]              bufSize,
  output logic [IdxW-1:0]               bufIdx,
  output logic [SizeW-1:0]              offset,
  output logic                          atEnd,
  output logic [AddrW-1:0]              wrAddr
);
  localparam logic [SizeW-1:0] WordBytes = SizeW'(4);

  assign atEnd  = (offset == bufSize - WordBytes);
  assign wrAddr = baseAddr[bufIdx] + AddrW'(offset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufIdx <= '0;
      offset <= '0;
    end else if (cmd.restart) begin
      bufIdx <= '0;
      offset <= '0;
    end else if (cmd.advance) begin
      if (atEnd) begin
        offset <= '0;
        bufIdx <= bufIdx + IdxW'(1);   // natural wrap 3 -> 0
      end else begin
        offset <= offset + WordBytes;
      end
    end
  end
endmodule

// File: rtl/rdw_ctrl.sv
module rdw_ctrl
  import rdw_pkg::*;
#(
  parameter int RecWords = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic              inValid,
  output logic              inReady,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic [NumBuf-1:0] bufRelease,
  input  logic [IdxW-1:0]   bufIdx,
  input  logic              atEnd,
  output dpCmd_t            cmd,
  output logic              doneValid,
  output logic [IdxW-1:0]   doneIdx,
  output logic              overflow,
  output logic              stopped
);
  localparam int CntW = (RecWords > 1) ? $clog2(RecWords) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(RecWords - 1);

  logic              run;
  logic [CntW-1:0]   recCnt;
  logic              dropReg;
  logic [NumBuf-1:0] busy;
  logic              gate, recStart, dropNow, accept;

  assign recStart = (recCnt == '0);
  assign gate     = run && (traceEn || !recStart);
  assign dropNow  = recStart ? busy[bufIdx] : dropReg;
  assign inReady  = gate && (dropNow || wrReady);
  assign wrValid  = gate && !dropNow && inValid;
  assign accept   = inValid && inReady;

  assign cmd.restart = !run && traceEn;
  assign cmd.advance = accept && !dropNow;
  assign doneValid   = cmd.advance && atEnd;
  assign doneIdx     = bufIdx;
  assign stopped     = !run;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run      <= 1'b0;
      recCnt   <= '0;
      dropReg  <= 1'b0;
      overflow <= 1'b0;
    end else if (cmd.restart) begin
      run      <= 1'b1;
      recCnt   <= '0;
      dropReg  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (accept) begin
        recCnt <= (recCnt == LastCnt) ? '0 : recCnt + CntW'(1);
        if (recStart) begin
          dropReg <= busy[bufIdx];
          if (busy[bufIdx]) overflow <= 1'b1;
        end
      end
      if (run && !traceEn && recStart) run <= 1'b0;
    end
  end

  for (genvar i = 0; i < NumBuf; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)                                 busy[i] <= 1'b0;
      else if (doneValid && doneIdx == IdxW'(i)) busy[i] <= 1'b1;
      else if (bufRelease[i])                    busy[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rdw_ring_writer.sv
module rdw_ring_writer
  import rdw_pkg::*;
#(
  parameter int AddrW    = 32,
  parameter int SizeW    = 24,
  parameter int RecWords = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          traceEn,
  input  logic [31:0]                   inData,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [NumBuf-1:0][AddrW-1:0]  baseAddr,
  input  logic [SizeW-1:0]              bufSize,
  input  logic [NumBuf-1:0]             bufRelease,
  output logic [AddrW-1:0]              wrAddr,
  output logic [31:0]                   wrData,
  output logic                          wrValid,
  input  logic                          wrReady,
  output logic                          doneValid,
  output logic [IdxW-1:0]               doneIdx,
  output logic                          overflow,
  output logic                          stopped,
  output logic [IdxW-1:0]               fillIdx,
  output logic [SizeW-1:0]              fillOffset
);
  dpCmd_t cmd;
  logic   atEnd;

  assign wrData = inData;

  rdw_ctrl #(.RecWords(RecWords)) u_ctrl (
    .clk(clk), .rstN(rstN), .traceEn(traceEn),
    .inValid(inValid), .inReady(inReady),
    .wrValid(wrValid), .wrReady(wrReady),
    .bufRelease(bufRelease), .bufIdx(fillIdx), .atEnd(atEnd),
    .cmd(cmd), .doneValid(doneValid), .doneIdx(doneIdx),
    .overflow(overflow), .stopped(stopped)
  );

  rdw_datapath #(.AddrW(AddrW), .SizeW(SizeW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .baseAddr(baseAddr), .bufSize(bufSize),
    .bufIdx(fillIdx), .offset(fillOffset), .atEnd(atEnd),
    .wrAddr(wrAddr)
  );
endmodule

// File: rtl/rdw_checker.sv
module rdw_checker #(
  parameter int SizeW = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             traceEn,
  input logic             inReady,
  input logic             wrValid,
  input logic             wrReady,
  input logic             doneValid,
  input logic [1:0]       doneIdx,
  input logic             overflow,
  input logic             stopped,
  input logic [1:0]       fillIdx,
  input logic [SizeW-1:0] fillOffset
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !doneValid) |=>
      (fillOffset == $past(fillOffset) + SizeW'(4)) && $stable(fillIdx));

  p_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (fillOffset == '0) && (fillIdx == $past(doneIdx) + 2'd1));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneIdx == 2'd3 && traceEn) |=> (fillIdx == 2'd0));

  p_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (wrValid && wrReady && doneIdx == fillIdx));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> (!inReady && !wrValid && !doneValid));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !stopped) |=> overflow);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && traceEn) |=>
      (!stopped && fillIdx == 2'd0 && fillOffset == '0 && !overflow));
endmodule

bind rdw_ring_writer rdw_checker #(.SizeW(SizeW)) u_chk (
  .clk(clk), .rstN(rstN), .traceEn(traceEn), .inReady(inReady),
  .wrValid(wrValid), .wrReady(wrReady), .doneValid(doneValid),
  .doneIdx(doneIdx), .overflow(overflow), .stopped(stopped),
  .fillIdx(fillIdx), .fillOffset(fillOffset)
);

// File: tb/tb_rdw_ring_writer.sv
module tb_rdw_ring_writer;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              traceEn = 1'b0;
  logic [31:0]       inData = '0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [3:0][31:0]  baseAddr;
  logic [23:0]       bufSize;
  logic [3:0]        bufRelease = '0;
  logic [31:0]       wrAddr;
  logic [31:0]       wrData;
  logic              wrValid;
  logic              wrReady = 1'b1;
  logic              doneValid;
  logic [1:0]        doneIdx;
  logic              overflow;
  logic              stopped;
  logic [1:0]        fillIdx;
  logic [23:0]       fillOffset;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [1:0]  mIdx = '0;
  int unsigned mOff = 0;
  int unsigned mSize = 48;
  int unsigned seq = 0;

  always #4 clk = ~clk;

  rdw_ring_writer dut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .inData(inData),
    .inValid(inValid), .inReady(inReady), .baseAddr(baseAddr),
    .bufSize(bufSize), .bufRelease(bufRelease), .wrAddr(wrAddr),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .doneValid(doneValid), .doneIdx(doneIdx), .overflow(overflow),
    .stopped(stopped), .fillIdx(fillIdx), .fillOffset(fillOffset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // present one word; expWrite says whether it must appear as a write
  task automatic pushWord(input bit expWrite);
    logic [31:0] d;
    logic [31:0] expAddr;
    bit expDone;
    seq++;
    d = 32'hA500_0000 + seq;
    @(negedge clk);
    inValid = 1'b1;
    inData  = d;
    #1;
    chk(inReady == 1'b1, "R1", "inReady", inReady, 1);
    if (expWrite) begin
      expAddr = baseAddr[mIdx] + mOff;
      expDone = (mOff == mSize - 4);
      chk(wrValid == 1'b1, "R1", "wrValid", wrValid, 1);
      chk(wrAddr == expAddr, "R1", "wrAddr", wrAddr, expAddr);
      chk(wrData == d, "R1", "wrData", wrData, d);
      chk(doneValid == expDone, "R4", "doneValid", doneValid, expDone);
      if (expDone) chk(doneIdx == mIdx, "R4", "doneIdx", doneIdx, mIdx);
    end else begin
      chk(wrValid == 1'b0, "R8", "wrValid on dropped word", wrValid, 0);
      chk(doneValid == 1'b0, "R8", "doneValid on dropped word", doneValid, 0);
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
    if (expWrite) begin
      if (mOff == mSize - 4) begin
        mOff = 0;
        mIdx = mIdx + 2'd1;
      end else begin
        mOff = mOff + 4;
      end
    end
  endtask

  task automatic releaseBuf(input int i);
    @(negedge clk);
    bufRelease[i] = 1'b1;
    @(posedge clk);
    #1;
    bufRelease = '0;
  endtask

  task automatic checkPos(input string req);
    @(negedge clk);
    #1;
    chk(fillIdx == mIdx, req, "fillIdx", fillIdx, mIdx);
    chk(fillOffset == mOff, req, "fillOffset", fillOffset, mOff);
  endtask

  task automatic startTrace();
    @(negedge clk);
    traceEn = 1'b1;
    @(negedge clk);
    #1;
    mIdx = '0;
    mOff = 0;
    chk(stopped == 1'b0, "R10", "stopped after enable", stopped, 0);
    chk(fillIdx == 2'd0, "R10", "fillIdx after enable", fillIdx, 0);
    chk(fillOffset == 24'd0, "R10", "fillOffset after enable", fillOffset, 0);
    chk(overflow == 1'b0, "R10", "overflow after enable", overflow, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    chk(stopped == 1'b1, "R11", "stopped", stopped, 1);
    chk(inReady == 1'b0, "R11", "inReady", inReady, 0);
    chk(wrValid == 1'b0, "R11", "wrValid", wrValid, 0);
    chk(doneValid == 1'b0, "R11", "doneValid", doneValid, 0);
    chk(overflow == 1'b0, "R11", "overflow", overflow, 0);
    chk(fillIdx == 2'd0, "R11", "fillIdx", fillIdx, 0);
    chk(fillOffset == 24'd0, "R11", "fillOffset", fillOffset, 0);
  endtask

  // R2 R3: fill all four regions in order, releasing each, then wrap
  task automatic testFillRing();
    startTrace();
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 12; w++) pushWord(1'b1);
      checkPos("R2");
      releaseBuf(b);
    end
    chk(mIdx == 2'd0, "R3", "model wrapped", mIdx, 0);
    checkPos("R3");
    for (int w = 0; w < 4; w++) pushWord(1'b1);
    checkPos("R3");
  endtask

  // R1: write port stalled -> input stalled, position holds
  task automatic testBackpressure();
    @(negedge clk);
    wrReady = 1'b0;
    inValid = 1'b1;
    inData  = 32'hDEAD_BEEF;
    #1;
    chk(inReady == 1'b0, "R1", "inReady under stall", inReady, 0);
    chk(wrValid == 1'b1, "R1", "wrValid under stall", wrValid, 1);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    wrReady = 1'b1;
    checkPos("R1");
  endtask

  // R6 R7: disable mid-record, finish record, then stop and report
  task automatic testStop();
    pushWord(1'b1);
    pushWord(1'b1);
    traceEn = 1'b0;
    pushWord(1'b1);
    pushWord(1'b1);
    @(negedge clk);
    inValid = 1'b1;
    inData  = 32'h1234_5678;
    #1;
    chk(inReady == 1'b0, "R6", "inReady after record end", inReady, 0);
    chk(wrValid == 1'b0, "R6", "wrValid after record end", wrValid, 0);
    @(negedge clk);
    #1;
    chk(stopped == 1'b1, "R6", "stopped", stopped, 1);
    chk(inReady == 1'b0, "R6", "inReady while stopped", inReady, 0);
    inValid = 1'b0;
    chk(fillIdx == 2'd0, "R7", "stop region", fillIdx, 0);
    chk(fillOffset == 24'd32, "R7", "stop offset", fillOffset, 32);
  endtask

  // R8 R9: no releases -> wrap into a held region drops the record
  task automatic testOverflow();
    startTrace();
    for (int w = 0; w < 48; w++) pushWord(1'b1);
    checkPos("R8");
    for (int w = 0; w < 4; w++) pushWord(1'b0);
    checkPos("R8");
    chk(overflow == 1'b1, "R8", "overflow set", overflow, 1);
    releaseBuf(0);
    for (int w = 0; w < 4; w++) pushWord(1'b1);
    checkPos("R9");
    chk(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);
  endtask

  // R5: a 4 MiB region
  task automatic testLargeSize();
    @(negedge clk);
    traceEn = 1'b0;
    @(negedge clk);
    #1;
    chk(stopped == 1'b1, "R6", "stopped at boundary", stopped, 1);
    releaseBuf(1);
    releaseBuf(2);
    releaseBuf(3);
    bufSize = 24'h40_0000;
    mSize = 32'h40_0000;
    startTrace();
    for (int w = 0; w < 16; w++) pushWord(1'b1);
    checkPos("R5");
    chk(fillOffset == 24'd64, "R5", "offset in large region", fillOffset, 64);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    baseAddr[0] = 32'h0000_1000;
    baseAddr[1] = 32'h0000_2000;
    baseAddr[2] = 32'h0000_3000;
    baseAddr[3] = 32'h0000_4000;
    bufSize = 24'd48;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFillRing();
    testBackpressure();
    testStop();
    testOverflow();
    testLargeSize();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule